// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-programmed station-management master. It serialises a 32-bit clause 22 management frame onto a management clock and data pair. It can put an optional run of 32 idle ones ahead of the frame. On a read it captures the sixteen data bits that the PHY returns. Software reaches it through a small register bus with four word registers:

- a frame register that holds the outgoing frame and receives read data;
- an 8-bit clock/configuration register;
- a sticky completion-event register;
- an interrupt mask register.

Launching a frame depends on which register is written and on what the other register holds at that moment. A write to the frame register launches only when the configuration register is already nonzero. A write to the configuration register launches only when it moves from zero to nonzero while the frame register holds a nonzero value. Software that wants to enable the clock without launching a frame first writes zero to the frame register. Every launched frame ends by setting the completion event. The event drives a level interrupt through the mask.

Top module: `mdio_ctrl`

## Requirements
- R1: A write to the frame register (address 0) launches a frame only if the configuration register (address 1) is nonzero at the time of the write; otherwise no frame appears and no event is set.
- R2: A write to the configuration register launches one frame, and exactly one completion event follows, when three conditions hold: the frame register is nonzero, the configuration register currently reads zero, and the written byte is nonzero.
- R3: A configuration write that does not meet the R2 condition launches nothing, and this includes a change between two nonzero values.
- R4: Each frame is preceded by 32 driven ones unless configuration bit 7 is set, in which case the frame begins directly with its start bits.
- R5: Event bit 0 (address 2) is set when a frame completes. It stays set until a write with bit 0 equal to 1 reaches address 2. Writing 0 there leaves it set.
- R6: After the frame register is written with zero, a configuration write from zero to nonzero launches no frame.
- R7: For a read frame (bits 29:28 = 10), the controller releases the data line from the first turnaround bit onward. It samples 16 bits on rising clock edges and stores them in frame bits 15:0, leaving bits 31:16 unchanged, no later than the cycle in which the event bit becomes visible.
- R8: The output irq is high exactly one cycle after both event bit 0 and mask bit 0 (address 3) are high, and low otherwise.
- R9: While a frame is in progress, further starts are blocked and writes to the frame register are dropped.
- R10: The management clock half-period is configuration bits 6:1 times 2 system clocks. A value of zero holds the clock low.
- R11: The data output changes only while the management clock is low, one system clock after its falling edge.
- R12: Frame bits are sent most significant first: start bits 31:30, opcode 29:28 (01 write, 10 read), PHY address 27:23, register address 22:18, turnaround 17:16, data 15:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | 2 | Register select: 0 frame, 1 config, 2 event, 3 mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data in |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check the following:
- a configuration write to an already nonzero value, or a frame write while the configuration is zero, never produces a start pulse;
- no start coincides with a busy frame;
- the event bit holds until a one is written to clear it;
- irq follows the masked event;
- a zero divider keeps the clock low;
- the data output moves only while the clock is low.

Only the bench scenarios can show whole-frame behaviour, which a PHY model decodes and compares against a queue of expected frames. These scenarios cover the zero-to-nonzero launch producing exactly one frame, read data landing in the low half of the frame register, the suppressed preamble, the clock period, and the arming by a zero frame write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    A_FRAME  = 2'd0,
    A_CLKCFG = 2'd1,
    A_EVENT  = 2'd2,
    A_MASK   = 2'd3
  } reg_addr_e;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             mdc_rise,
  output logic             mdc_fall
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt;

  assign half = {div, 1'b0};

  always_ff @(posedge clk) begin
    if (rst || div == '0) begin
      cnt      <= '0;
      mdc      <= 1'b0;
      mdc_rise <= 1'b0;
      mdc_fall <= 1'b0;
    end else begin
      mdc_rise <= 1'b0;
      mdc_fall <= 1'b0;
      if (cnt >= half - 1'b1) begin
        cnt      <= '0;
        mdc      <= ~mdc;
        mdc_rise <= ~mdc;
        mdc_fall <= mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine #(
  parameter int FRAME_W = 32,
  parameter int PRE_W   = 32,
  parameter int DATA_W  = 16,
  parameter int TA_POS  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FRAME_W-1:0] frame,
  input  logic              no_pre,
  input  logic              mdc_rise,
  input  logic              mdc_fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  import mdio_pkg::*;

  localparam int TOT = FRAME_W + PRE_W;
  localparam int PW  = $clog2(TOT);
  localparam logic [PW-1:0] P_FIRST = PW'(PRE_W);
  localparam logic [PW-1:0] P_TA    = PW'(PRE_W + TA_POS);
  localparam logic [PW-1:0] P_DAT   = PW'(TOT - DATA_W);
  localparam logic [PW-1:0] P_LAST  = PW'(TOT - 1);

  logic              busy_q, run_q, is_rd, done_q, mo_q, oe_q;
  logic [PW-1:0]     ptr, ptr_nx;
  logic [TOT-1:0]    vec;
  logic [DATA_W-1:0] rd_sh;

  assign ptr_nx = ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      is_rd  <= 1'b0;
      done_q <= 1'b0;
      mo_q   <= 1'b1;
      oe_q   <= 1'b0;
      ptr    <= '0;
      vec    <= '0;
      rd_sh  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        run_q  <= 1'b0;
        is_rd  <= (frame[FRAME_W-3 -: 2] == OP_READ);
        vec    <= no_pre ? {frame, {PRE_W{1'b1}}} : {{PRE_W{1'b1}}, frame};
        ptr    <= no_pre ? P_FIRST : '0;
      end else if (busy_q) begin
        if (mdc_fall) begin
          if (!run_q) begin
            run_q <= 1'b1;
            mo_q  <= vec[TOT-1];
            oe_q  <= !(is_rd && ptr >= P_TA);
          end else begin
            ptr  <= ptr_nx;
            vec  <= {vec[TOT-2:0], 1'b0};
            mo_q <= vec[TOT-2];
            oe_q <= !(is_rd && ptr_nx >= P_TA);
          end
        end
        if (mdc_rise && run_q) begin
          if (is_rd && ptr >= P_DAT) rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
          if (ptr == P_LAST) begin
            busy_q <= 1'b0;
            run_q  <= 1'b0;
            done_q <= 1'b1;
            oe_q   <= 1'b0;
            mo_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_valid = is_rd;
  assign rd_data  = rd_sh;
  assign mdio_o   = mo_q;
  assign mdio_oe  = oe_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs #(
  parameter int FRAME_W = 32,
  parameter int CFG_W   = 8,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_addr,
  input  logic [FRAME_W-1:0] bus_wdata,
  output logic [FRAME_W-1:0] bus_rdata,
  input  logic               busy,
  input  logic               done,
  input  logic               rd_valid,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [FRAME_W-1:0] frame_q,
  output logic [CFG_W-1:0]   cfg_q,
  output logic               start_q,
  output logic               ev_q,
  output logic               mask_q,
  output logic               irq
);
  import mdio_pkg::*;

  logic wr_frame, wr_cfg, wr_ev, wr_mask, blocked;
  logic [CFG_W-1:0] new_cfg;

  assign wr_frame = bus_wr && (bus_addr == A_FRAME);
  assign wr_cfg   = bus_wr && (bus_addr == A_CLKCFG);
  assign wr_ev    = bus_wr && (bus_addr == A_EVENT);
  assign wr_mask  = bus_wr && (bus_addr == A_MASK);
  assign blocked  = busy || start_q;
  assign new_cfg  = bus_wdata[CFG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q   <= '0;
      cfg_q     <= '0;
      start_q   <= 1'b0;
      ev_q      <= 1'b0;
      mask_q    <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      start_q <= 1'b0;
      if (wr_frame && !blocked) begin
        frame_q <= bus_wdata;
        if (cfg_q != '0) start_q <= 1'b1;
      end
      if (wr_cfg) begin
        cfg_q <= new_cfg;
        if (!blocked && frame_q != '0 && cfg_q == '0 && new_cfg != '0)
          start_q <= 1'b1;
      end
      if (done && rd_valid) frame_q[DATA_W-1:0] <= rd_data;
      if (done) ev_q <= 1'b1;
      else if (wr_ev && bus_wdata[0]) ev_q <= 1'b0;
      if (wr_mask) mask_q <= bus_wdata[0];
      irq <= ev_q && mask_q;
      if (bus_rd) begin
        case (bus_addr)
          A_FRAME:  bus_rdata <= frame_q;
          A_CLKCFG: bus_rdata <= FRAME_W'(cfg_q);
          A_EVENT:  bus_rdata <= FRAME_W'(ev_q);
          default:  bus_rdata <= FRAME_W'(mask_q);
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl #(
  parameter int FRAME_W = 32,
  parameter int CFG_W   = 8,
  parameter int DATA_W  = 16,
  parameter int PRE_W   = 32,
  parameter int TA_POS  = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_addr,
  input  logic [FRAME_W-1:0] bus_wdata,
  output logic [FRAME_W-1:0] bus_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i,
  output logic               irq
);
  localparam int DIV_W = CFG_W - 2;

  logic [FRAME_W-1:0] frame_q;
  logic [CFG_W-1:0]   cfg_q;
  logic               start_q, ev_q, mask_q;
  logic               busy, done, rd_valid, mdc_rise, mdc_fall;
  logic [DATA_W-1:0]  rd_data;

  mdio_regs #(.FRAME_W(FRAME_W), .CFG_W(CFG_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data), .frame_q(frame_q), .cfg_q(cfg_q),
    .start_q(start_q), .ev_q(ev_q), .mask_q(mask_q), .irq(irq)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .div(cfg_q[CFG_W-2:1]),
    .mdc(mdc), .mdc_rise(mdc_rise), .mdc_fall(mdc_fall)
  );

  mdio_engine #(.FRAME_W(FRAME_W), .PRE_W(PRE_W), .DATA_W(DATA_W), .TA_POS(TA_POS)) u_eng (
    .clk(clk), .rst(rst), .start(start_q), .frame(frame_q), .no_pre(cfg_q[CFG_W-1]),
    .mdc_rise(mdc_rise), .mdc_fall(mdc_fall), .mdio_i(mdio_i), .busy(busy),
    .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic             wd0,
  input logic [CFG_W-1:0] cfg_q,
  input logic             start_q,
  input logic             busy,
  input logic             ev_q,
  input logic             mask_q,
  input logic             irq,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe
);
  p_frame_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0 && cfg_q == '0) |=> !start_q);

  p_cfg_retrigger_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd1 && cfg_q != '0) |=> !start_q);

  p_ev_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_q && !(bus_wr && bus_addr == 2'd2 && wd0)) |=> ev_q);

  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ev_q && mask_q));

  p_busy_block_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start_q);

  p_mdc_stop_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[CFG_W-2:1] == '0) |=> !mdc);

  p_mdio_edge_r11: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && !$stable(mdio_o)) |-> !mdc);
endmodule

bind mdio_ctrl mdio_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .wd0(bus_wdata[0]),
  .cfg_q(cfg_q), .start_q(start_q), .busy(busy), .ev_q(ev_q), .mask_q(mask_q),
  .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_ctrl_tb;
  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
    logic [5:0]  pre;
  } item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, irq;
  logic mdio_i = 1'b1;
  logic phy_next = 1'b1;

  int checks = 0, fails = 0, frames_seen = 0, oe_err = 0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  mdio_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mkframe(logic [1:0] op, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
    return {2'b01, op, phy, ra, 2'b10, d};
  endfunction

  function automatic logic [15:0] reply(logic [4:0] phy, logic [4:0] ra);
    return {phy, ra, 6'b101101};
  endfunction

  task automatic expect_frame(logic [1:0] op, logic [4:0] phy, logic [4:0] ra, logic [15:0] d, logic [5:0] pre);
    item_t it;
    it.op = op; it.phy = phy; it.regad = ra; it.data = d; it.pre = pre;
    exp_q.push_back(it);
  endtask

  // PHY model and scoreboard monitor
  int ones = 0, cnt = 0, pre_seen = 0;
  bit in_frame = 1'b0, rd_mode = 1'b0;
  logic [31:0] sh = 32'd0;
  logic [15:0] rep = 16'd0;

  always @(negedge mdc) mdio_i = phy_next;

  always @(posedge mdc) begin
    if (!in_frame) begin
      if (mdio_oe) begin
        if (mdio_o) ones++;
        else begin
          in_frame = 1'b1; cnt = 1; sh = 32'd0; pre_seen = ones; rd_mode = 1'b0;
        end
      end else ones = 0;
    end else begin
      if (rd_mode && cnt >= 14 && mdio_oe) oe_err++;
      sh = {sh[30:0], (mdio_oe ? mdio_o : mdio_i)};
      cnt++;
      if (cnt == 14) begin
        rd_mode = (sh[11:10] == 2'b10);
        rep = reply(sh[9:5], sh[4:0]);
        phy_next = 1'b1;
      end else if (rd_mode && cnt == 15) phy_next = 1'b0;
      else if (rd_mode && cnt >= 16 && cnt < 32) phy_next = rep[31-cnt];
      if (cnt == 32) begin
        item_t got, want;
        phy_next = 1'b1;
        frames_seen++;
        got.op = sh[29:28]; got.phy = sh[27:23]; got.regad = sh[22:18];
        got.data = sh[15:0]; got.pre = 6'(pre_seen);
        if (exp_q.size() == 0) chk(1'b0, "R12 unexpected frame", 64'(got), 64'd0);
        else begin
          want = exp_q.pop_front();
          chk(got[33:6] == want[33:6], "R12 frame fields", 64'(got[33:6]), 64'(want[33:6]));
          chk(got.pre == want.pre, "R4 preamble length", 64'(got.pre), 64'(want.pre));
        end
        in_frame = 1'b0; ones = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hi;
    idle(4); rst = 1'b0; idle(2);

    // reset state
    rd(2'd0, v); chk(v == 0, "R1 reset frame", 64'(v), 0);
    rd(2'd1, v); chk(v == 0, "R10 reset config", 64'(v), 0);
    rd(2'd2, v); chk(v == 0, "R5 reset event", 64'(v), 0);
    chk(!irq && !mdc && !mdio_oe, "R8 reset outputs", 64'({irq, mdc, mdio_oe}), 0);

    // R1: frame write with config zero does nothing
    wr(2'd0, mkframe(2'b01, 5'd3, 5'd4, 16'hA5C3));
    idle(200);
    chk(frames_seen == 0, "R1 no frame with config zero", 64'(frames_seen), 0);
    rd(2'd2, v); chk(v == 0, "R1 no event", 64'(v), 0);
    chk(!mdc, "R10 clock held low", 64'(mdc), 0);

    // R2: spurious-start scenario, config zero -> nonzero with frame nonzero
    expect_frame(2'b01, 5'd3, 5'd4, 16'hA5C3, 6'd32);
    wr(2'd1, 32'h02);
    idle(600);
    chk(frames_seen == 1, "R2 exactly one frame", 64'(frames_seen), 1);
    rd(2'd2, v); chk(v == 1, "R2 one event", 64'(v), 1);

    // R5: sticky event, write-one-to-clear
    wr(2'd2, 32'h0); rd(2'd2, v); chk(v == 1, "R5 zero write keeps event", 64'(v), 1);
    wr(2'd2, 32'h1); rd(2'd2, v); chk(v == 0, "R5 one write clears event", 64'(v), 0);

    // R3: nonzero -> nonzero config write
    wr(2'd1, 32'h04);
    idle(600);
    chk(frames_seen == 1, "R3 no frame on retarget", 64'(frames_seen), 1);
    rd(2'd2, v); chk(v == 0, "R3 no event on retarget", 64'(v), 0);

    // R10: half period = 2*2 = 4 clocks
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
    hi = 0;
    while (mdc) begin hi++; @(negedge clk); end
    chk(hi == 4, "R10 half period", 64'(hi), 4);

    // R7: read frame
    expect_frame(2'b10, 5'd5, 5'd9, reply(5'd5, 5'd9), 6'd32);
    wr(2'd0, mkframe(2'b10, 5'd5, 5'd9, 16'h0));
    idle(800);
    chk(frames_seen == 2, "R1 frame with config nonzero", 64'(frames_seen), 2);
    rd(2'd0, v);
    chk(v == mkframe(2'b10, 5'd5, 5'd9, reply(5'd5, 5'd9)), "R7 read data stored", 64'(v),
        64'(mkframe(2'b10, 5'd5, 5'd9, reply(5'd5, 5'd9))));
    chk(oe_err == 0, "R7 line released from turnaround", 64'(oe_err), 0);

    // R8: interrupt masking
    idle(2); chk(!irq, "R8 masked irq low", 64'(irq), 0);
    wr(2'd3, 32'h1); idle(2); chk(irq, "R8 unmasked irq high", 64'(irq), 1);
    wr(2'd2, 32'h1); idle(2); chk(!irq, "R8 irq drops on clear", 64'(irq), 0);

    // R9: frame write while busy is dropped
    expect_frame(2'b01, 5'd1, 5'd2, 16'h1234, 6'd32);
    wr(2'd0, mkframe(2'b01, 5'd1, 5'd2, 16'h1234));
    idle(20);
    wr(2'd0, mkframe(2'b01, 5'd6, 5'd7, 16'h5678));
    idle(1000);
    chk(frames_seen == 3, "R9 one frame only", 64'(frames_seen), 3);
    rd(2'd0, v); chk(v == mkframe(2'b01, 5'd1, 5'd2, 16'h1234), "R9 busy write dropped", 64'(v),
        64'(mkframe(2'b01, 5'd1, 5'd2, 16'h1234)));
    wr(2'd2, 32'h1);

    // R6: arm with zero frame, then enable without a launch
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h82);
    idle(400);
    chk(frames_seen == 3, "R6 armed enable launches nothing", 64'(frames_seen), 3);
    rd(2'd2, v); chk(v == 0, "R6 no event", 64'(v), 0);

    // R4: suppressed preamble
    expect_frame(2'b01, 5'd7, 5'd17, 16'hBEEF, 6'd0);
    wr(2'd0, mkframe(2'b01, 5'd7, 5'd17, 16'hBEEF));
    idle(500);
    chk(frames_seen == 4, "R4 short frame sent", 64'(frames_seen), 4);
    chk(irq, "R8 irq after short frame", 64'(irq), 1);
    chk(exp_q.size() == 0, "R12 all expected frames seen", 64'(exp_q.size()), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule